// File: doc/BRIEF.md
# Panel Self-Refresh State Controller

This block follows one display pipe through its panel self-refresh lifecycle and reports where it is as a numbered state code. Software drives two level controls, an enable and an active-entry request. The hardware supplies a frame-boundary pulse and a single-frame-update request. Some steps are taken only on a software request. Other steps are taken by the controller itself at the next frame boundary.

When the link leaves self-refresh, the controller raises a wake-up request toward an auxiliary-channel engine. The request carries a sink register address and a data byte. It stays up until that engine acknowledges it. An in-transition flag lets software wait for a quiet point before it forces the controller back to the disabled state.

States and transitions:
- ST_OFF (0), disabled.
- ST_IDLE (1), inactive.
- ST_ENTERING (2), moving toward active while a static frame is sent.
- ST_SELF_REFRESH (3), active with no remote frame buffer update.
- ST_SINGLE_UPDATE (4), active with a single frame update.
- ST_LEAVING (5), exit.
- Named transitions are: wake (0→1), arm (1→2), settle (2→3), refresh (3→4), refresh-done (4→3), quit (3→5), rejoin (5→1) and shutdown (any state→0).

Top module: `psr_state_ctrl`

## Requirements
- R1: During and right after reset, state_code is 0, in_transition is 0 and aux_req is 0. state_code only takes the values 0 to 5: 0 = disabled, 1 = inactive, 2 = entering, 3 = self-refresh, 4 = single update, 5 = exit.
- R2: In state 0 with enable high, the state becomes 1 one clock later (wake).
- R3: In state 1 with enable and active_entry both high, the state becomes 2 one clock later (arm).
- R4: State 2 holds until the first cycle with frame_tick high. The state then becomes 3 one clock later, with no software action needed (settle).
- R5: In state 3 with enable high and active_entry low, the state becomes 5 one clock later and never passes through 4 (quit). This has priority over a single-update request.
- R6: In state 3 with active_entry high and update_req high, the state becomes 4 (refresh). State 4 returns to 3 one clock after the first frame_tick (refresh-done).
- R7: State 5 returns to 1 one clock after the first frame_tick (rejoin).
- R8: in_transition is 1 exactly while state_code is 2 or 5.
- R9: On the clock edge that enters state 5, aux_req goes high. aux_addr reads 20'h00600 and aux_data reads 8'h01.
- R10: aux_req stays high until a cycle in which aux_ack is high. It is low one clock after that cycle.
- R11: With enable low, states 1, 3 and 4 go to 0 one clock later (shutdown). States 2 and 5 first finish their frame-tick step. The controller then shuts down on the next clock.
- R12: active_entry has no effect in state 0. update_req and frame_tick have no effect in state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Software enable for self-refresh |
| active_entry | input | 1 | Software request to enter or stay in active self-refresh |
| frame_tick | input | 1 | One-cycle frame-boundary pulse |
| update_req | input | 1 | Single-frame-update request |
| aux_ack | input | 1 | Auxiliary engine accepted the wake-up write |
| state_code | output | 3 | Current lifecycle state number |
| in_transition | output | 1 | High while in state 2 or 5 |
| aux_req | output | 1 | Pending wake-up write request |
| aux_addr | output | 20 | Sink register address of the wake-up write |
| aux_data | output | 8 | Data byte of the wake-up write |

## Verification
The state register drives state_code directly. Any wrong next-state choice therefore shows on the port one clock after the input that caused it. The bench compares every cycle, so a skipped, added or late transition is caught at that cycle. A wrong exit path shows in two ways: state 4 appears on state_code, or aux_req rises late or fails to rise on the edge that enters state 5. A fault in the handshake shows either as aux_req dropping before aux_ack, or as aux_req still high one clock after aux_ack.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_OFF           = 3'd0,
        ST_IDLE          = 3'd1,
        ST_ENTERING      = 3'd2,
        ST_SELF_REFRESH  = 3'd3,
        ST_SINGLE_UPDATE = 3'd4,
        ST_LEAVING       = 3'd5
    } psr_state_e;

    function automatic logic is_transitional(psr_state_e s);
        return (s == ST_ENTERING) || (s == ST_LEAVING);
    endfunction
endpackage

// File: rtl/psr_fsm.sv
module psr_fsm
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       active_entry,
    input  logic       frame_tick,
    input  logic       update_req,
    output psr_state_e state_q,
    output logic       exit_start
);
    psr_state_e state_d;
    logic       busy;

    assign busy = is_transitional(state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (!enable && !busy) begin
            state_d = ST_OFF;                                  // shutdown
        end else begin
            unique case (state_q)
                ST_OFF:           state_d = ST_IDLE;           // wake
                ST_IDLE:          if (active_entry) state_d = ST_ENTERING;
                ST_ENTERING:      if (frame_tick) state_d = ST_SELF_REFRESH;
                ST_SELF_REFRESH: begin
                    if (!active_entry)   state_d = ST_LEAVING;       // quit
                    else if (update_req) state_d = ST_SINGLE_UPDATE; // refresh
                end
                ST_SINGLE_UPDATE: if (frame_tick) state_d = ST_SELF_REFRESH;
                ST_LEAVING:       if (frame_tick) state_d = ST_IDLE;
                default:          state_d = ST_OFF;
            endcase
        end
    end

    assign exit_start = (state_q != ST_LEAVING) && (state_d == ST_LEAVING);

    a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && enable) |=> state_q == ST_IDLE);
    a_r4_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTERING && frame_tick) |=> state_q == ST_SELF_REFRESH);
    a_r5_quit_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELF_REFRESH && enable && !active_entry) |=> state_q == ST_LEAVING);
    a_r7_rejoin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAVING && frame_tick) |=> state_q == ST_IDLE);
    a_r11_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && (state_q == ST_IDLE || state_q == ST_SELF_REFRESH ||
                     state_q == ST_SINGLE_UPDATE)) |=> state_q == ST_OFF);
endmodule

// File: rtl/psr_wake_req.sv
module psr_wake_req #(
    parameter int          ADDR_W    = 20,
    parameter int          DATA_W    = 8,
    parameter logic [19:0] WAKE_ADDR = 20'h00600,
    parameter logic [7:0]  WAKE_DATA = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exit_start,
    input  logic              aux_ack,
    output logic              aux_req,
    output logic [ADDR_W-1:0] aux_addr,
    output logic [DATA_W-1:0] aux_data
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           req_q <= 1'b0;
        else if (exit_start)  req_q <= 1'b1;
        else if (aux_ack)     req_q <= 1'b0;
    end

    assign aux_req  = req_q;
    assign aux_addr = ADDR_W'(WAKE_ADDR);
    assign aux_data = DATA_W'(WAKE_DATA);

    a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
        exit_start |=> aux_req);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && !aux_ack) |=> aux_req);
endmodule

// File: rtl/psr_state_ctrl.sv
module psr_state_ctrl
    import psr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              active_entry,
    input  logic              frame_tick,
    input  logic              update_req,
    input  logic              aux_ack,
    output logic [2:0]        state_code,
    output logic              in_transition,
    output logic              aux_req,
    output logic [ADDR_W-1:0] aux_addr,
    output logic [DATA_W-1:0] aux_data
);
    psr_state_e cur_state;
    logic       exit_start;

    psr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .active_entry (active_entry),
        .frame_tick   (frame_tick),
        .update_req   (update_req),
        .state_q      (cur_state),
        .exit_start   (exit_start)
    );

    psr_wake_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .exit_start (exit_start),
        .aux_ack    (aux_ack),
        .aux_req    (aux_req),
        .aux_addr   (aux_addr),
        .aux_data   (aux_data)
    );

    // Output decode
    always_comb begin
        state_code    = cur_state;
        in_transition = is_transitional(cur_state);
    end

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd5);
    a_r9_req_in_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_req) |-> state_code == 3'd5);
endmodule

// File: tb/psr_state_ctrl_tb_top.sv
module psr_state_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 0, active_entry = 0, frame_tick = 0, update_req = 0, aux_ack = 0;
    logic [2:0]  state_code;
    logic        in_transition, aux_req;
    logic [19:0] aux_addr;
    logic [7:0]  aux_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    typedef struct {
        logic [2:0] st;
        logic       tr;
        logic       rq;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    psr_state_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .active_entry(active_entry),
        .frame_tick(frame_tick), .update_req(update_req), .aux_ack(aux_ack),
        .state_code(state_code), .in_transition(in_transition), .aux_req(aux_req),
        .aux_addr(aux_addr), .aux_data(aux_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply inputs at the falling edge, queue the outcome after the next rising edge
    task automatic drive(input logic en, input logic ae, input logic tk, input logic up,
                         input logic ak, input logic [2:0] st, input logic rq, input string tag);
        exp_t e;
        @(negedge clk);
        enable = en; active_entry = ae; frame_tick = tk; update_req = up; aux_ack = ak;
        e.st = st; e.tr = (st == 3'd2 || st == 3'd5); e.rq = rq; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " state"}, 32'(state_code), 32'(e.st));
            check("R8 in_transition", 32'(in_transition), 32'(e.tr));
            check({e.tag, " aux_req"}, 32'(aux_req), 32'(e.rq));
            if (e.rq) begin
                check("R9 aux_addr", 32'(aux_addr), 32'h600);
                check("R9 aux_data", 32'(aux_data), 32'h01);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'(state_code), 0);
        check("R1 reset flag", 32'(in_transition), 0);
        check("R1 reset aux_req", 32'(aux_req), 0);
        rst_n = 1'b1;
        //     en ae tk up ak  st rq
        drive(0, 1, 0, 0, 0, 0, 0, "R12 entry ignored when off");
        drive(1, 0, 0, 0, 0, 1, 0, "R2 wake");
        drive(1, 0, 0, 1, 0, 1, 0, "R12 update ignored idle");
        drive(1, 0, 1, 0, 0, 1, 0, "R12 tick ignored idle");
        drive(1, 1, 0, 0, 0, 2, 0, "R3 arm");
        drive(1, 1, 0, 0, 0, 2, 0, "R4 wait tick");
        drive(1, 1, 1, 0, 0, 3, 0, "R4 settle");
        drive(1, 1, 0, 1, 0, 4, 0, "R6 refresh");
        drive(1, 1, 0, 0, 0, 4, 0, "R6 hold single");
        drive(1, 1, 1, 0, 0, 3, 0, "R6 refresh done");
        drive(1, 0, 0, 1, 0, 5, 1, "R5 quit skips 4 / R9");
        drive(1, 0, 0, 0, 0, 5, 1, "R10 held");
        drive(1, 0, 1, 0, 1, 1, 0, "R7 rejoin / R10 ack");
        drive(1, 1, 0, 0, 0, 2, 0, "R3 re-arm");
        drive(0, 1, 0, 0, 0, 2, 0, "R11 wait in 2");
        drive(0, 1, 1, 0, 0, 3, 0, "R11 settle first");
        drive(0, 1, 0, 0, 0, 0, 0, "R11 shutdown from 3");
        drive(1, 0, 0, 0, 0, 1, 0, "R2 wake again");
        drive(1, 1, 0, 0, 0, 2, 0, "R3 arm");
        drive(1, 1, 1, 0, 0, 3, 0, "R4 settle");
        drive(1, 1, 0, 1, 0, 4, 0, "R6 refresh");
        drive(0, 1, 0, 0, 0, 0, 0, "R11 shutdown from 4");
        drive(1, 0, 0, 0, 0, 1, 0, "R2 wake");
        drive(0, 0, 0, 0, 0, 0, 0, "R11 shutdown from 1");
        drive(1, 0, 0, 0, 0, 1, 0, "R2 wake");
        drive(1, 1, 0, 0, 0, 2, 0, "R3 arm");
        drive(1, 1, 1, 0, 0, 3, 0, "R4 settle");
        drive(1, 0, 0, 0, 0, 5, 1, "R9 exit request");
        drive(0, 0, 0, 0, 0, 5, 1, "R11 wait in 5");
        drive(0, 0, 1, 0, 1, 1, 0, "R11 rejoin first / R10");
        drive(0, 0, 0, 0, 0, 0, 0, "R11 shutdown after exit");
        @(negedge clk);
        enable = 0; active_entry = 0; frame_tick = 0; update_req = 0; aux_ack = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule